// File: doc/BRIEF.md
# Shift-Flip-Logic Frame Buffer Writer

This block sits in the CPU write path of a bitmap frame buffer. The CPU can store a byte straight into the buffer. It can also store the byte through a second "alias" window. An alias store is not written as it arrives. The byte is first shifted right by a programmed pixel count. The bits that fall off the bottom of the previous alias byte are fed in at the top. The result can then be mirrored bit for bit. Finally it is merged with the byte already in the buffer by one of sixteen selectable logic functions, and the merged byte is written back.

Each alias store is a read-modify-write of the destination. The CPU ready output stays low until the write-back has happened. During the merge the block also detects collisions: if any set source pixel lands on a set destination pixel, a sticky intercept flag is raised. The CPU polls that flag through a status read, and the read clears it.

The frame-buffer RAM is external. It has a synchronous read port with one cycle of latency. The CPU address decoder is also external: it supplies the alias-window select and the byte offset inside the buffer.

Top module: `fbw_writer`

## Requirements
- R1: After reset, cpu_ready is 1, fb_re and fb_we are 0, the control register is 0, and a status read returns 0.
- R2: A store with cpu_alias=0 writes cpu_wdata unchanged to cpu_addr, with no frame-buffer read. It does not change the carried byte used by the shifter.
- R3: On an alias store, the source byte S is the low byte of {carry, cpu_wdata} shifted right by control bits [2:0]. Here carry is the data byte of the previous alias store, and it is replaced by the current cpu_wdata on every alias store.
- R4: When control bit 3 is 1, the shifted byte is bit-reversed (bit i moves to bit 7-i) before the merge. When bit 3 is 0 it passes unchanged.
- R5: Control bits [7:4] select the byte written back for destination D: 0:S, 1:S|D, 2:S|~D, 3:FF, 4:S&D, 5:D, 6:~(S^D), 7:~S|D, 8:S&~D, 9:S^D, 10:~D, 11:~(S&D), 12:00, 13:~S&D, 14:~(S|D), 15:~S.
- R6: An alias store whose S&D is nonzero sets the intercept flag. A status read returns the flag in bit 7 and 0 in bits [6:0].
- R7: The flag stays set until a status read clears it. If a status read coincides with the write-back that sets it, the flag stays set.
- R8: An alias store reads the destination in the first cycle after acceptance and writes it back in the second, at the same address, holding cpu_ready low for exactly those two cycles. A direct store holds it low for one cycle.
- R9: A store request presented while cpu_ready is 0 is not accepted and leaves the buffer unchanged.
- R10: The shift, flip and function are fixed when a store is accepted. A control write made while that store is in progress does not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value: [2:0] shift, [3] flip, [7:4] function |
| cpu_we | input | 1 | CPU store request, accepted when cpu_ready is 1 |
| cpu_alias | input | 1 | 1 = store through the transforming window, 0 = direct store |
| cpu_addr | input | AW | Byte offset inside the frame buffer |
| cpu_wdata | input | 8 | Store data |
| cpu_ready | output | 1 | High when a new store can be accepted |
| stat_re | input | 1 | Status read strobe; clears the intercept flag |
| stat_rdata | output | 8 | Status: intercept flag in bit 7 |
| fb_re | output | 1 | Frame-buffer read enable |
| fb_we | output | 1 | Frame-buffer write enable |
| fb_addr | output | AW | Frame-buffer address |
| fb_wdata | output | 8 | Frame-buffer write data |
| fb_rdata | input | 8 | Frame-buffer read data, valid one cycle after fb_re |

## Verification
The bench builds the block with its defaults: AW=13, covering an 8 KiB buffer, and DW=8, which gives a 3-bit shift field and an 8-bit control word. With these values every shift count from 0 to 7 can be reached. Flip and shift can be combined on a carried byte. Each of the sixteen functions is swept with walking-one source and destination bytes, so every single-pixel overlap, and so every intercept case, is exercised. Timing corners are driven directly at the ports: a store presented while busy, a control change during a store, and a status read in the write-back cycle.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } fbw_state_t;

  localparam int unsigned OPW = 4;
  typedef logic [OPW-1:0] fbw_op_t;
endpackage

// File: rtl/fbw_shift_flip.sv
module fbw_shift_flip #(
  parameter int unsigned DW  = 8,
  localparam int unsigned SHW = $clog2(DW)
) (
  input  logic [DW-1:0]  carry_i,
  input  logic [DW-1:0]  data_i,
  input  logic [SHW-1:0] shamt_i,
  input  logic           flip_i,
  output logic [DW-1:0]  src_o
);
  logic [2*DW-1:0] wide;
  logic [DW-1:0]   shifted;
  logic [DW-1:0]   mirrored;

  always_comb begin
    wide    = {carry_i, data_i} >> shamt_i;
    shifted = wide[DW-1:0];
  end

  for (genvar b = 0; b < DW; b++) begin : g_mirror
    assign mirrored[b] = shifted[DW-1-b];
  end

  assign src_o = flip_i ? mirrored : shifted;
endmodule

// File: rtl/fbw_logic_unit.sv
module fbw_logic_unit
  import fbw_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  fbw_op_t       op_i,
  input  logic [DW-1:0] s_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] res_o,
  output logic          hit_o
);
  always_comb begin
    case (op_i)
      4'd0:  res_o = s_i;
      4'd1:  res_o = s_i | d_i;
      4'd2:  res_o = s_i | ~d_i;
      4'd3:  res_o = '1;
      4'd4:  res_o = s_i & d_i;
      4'd5:  res_o = d_i;
      4'd6:  res_o = ~(s_i ^ d_i);
      4'd7:  res_o = ~s_i | d_i;
      4'd8:  res_o = s_i & ~d_i;
      4'd9:  res_o = s_i ^ d_i;
      4'd10: res_o = ~d_i;
      4'd11: res_o = ~(s_i & d_i);
      4'd12: res_o = '0;
      4'd13: res_o = ~s_i & d_i;
      4'd14: res_o = ~(s_i | d_i);
      default: res_o = ~s_i;
    endcase
    hit_o = |(s_i & d_i);
  end
endmodule

// File: rtl/fbw_seq.sv
module fbw_seq
  import fbw_pkg::*;
#(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n_s,
  input  logic          cpu_we,
  input  logic          cpu_alias,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [DW-1:0] src_i,
  input  fbw_op_t       op_i,
  input  logic [DW-1:0] lu_res_i,
  input  logic          lu_hit_i,
  input  logic          stat_re,
  output logic [DW-1:0] carry_o,
  output logic [DW-1:0] byte_o,
  output fbw_op_t       op_o,
  output logic          cpu_ready,
  output logic          fb_re,
  output logic          fb_we,
  output logic [AW-1:0] fb_addr,
  output logic [DW-1:0] fb_wdata,
  output logic          flag_o
);
  fbw_state_t    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] byte_q, carry_q;
  fbw_op_t       op_q;
  logic          alias_q, flag_q, flag_d;
  logic          accept, cap_en, carry_en;

  assign accept   = cpu_we && (state_q == ST_IDLE);
  assign cap_en   = accept;
  assign carry_en = accept && cpu_alias;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = cpu_alias ? ST_RD : ST_WR;
      ST_RD:   state_d = ST_WR;
      ST_WR:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    flag_d = flag_q;
    if (stat_re) flag_d = 1'b0;
    if (state_q == ST_WR && alias_q && lu_hit_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q  <= '0;
      byte_q  <= '0;
      op_q    <= '0;
      alias_q <= 1'b0;
    end else if (cap_en) begin
      addr_q  <= cpu_addr;
      byte_q  <= cpu_alias ? src_i : cpu_wdata;
      op_q    <= op_i;
      alias_q <= cpu_alias;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      carry_q <= '0;
    end else if (carry_en) begin
      carry_q <= cpu_wdata;
    end
  end

  assign carry_o   = carry_q;
  assign byte_o    = byte_q;
  assign op_o      = op_q;
  assign cpu_ready = (state_q == ST_IDLE);
  assign fb_re     = (state_q == ST_RD);
  assign fb_we     = (state_q == ST_WR);
  assign fb_addr   = addr_q;
  assign fb_wdata  = alias_q ? lu_res_i : byte_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/fbw_writer.sv
module fbw_writer
  import fbw_pkg::*;
#(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8,
  localparam int unsigned SHW = $clog2(DW),
  localparam int unsigned CW  = SHW + 1 + OPW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [CW-1:0] ctl_wdata,
  input  logic          cpu_we,
  input  logic          cpu_alias,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  input  logic          stat_re,
  output logic [DW-1:0] stat_rdata,
  output logic          fb_re,
  output logic          fb_we,
  output logic [AW-1:0] fb_addr,
  output logic [DW-1:0] fb_wdata,
  input  logic [DW-1:0] fb_rdata
);
  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic [CW-1:0] ctl_q;
  logic [DW-1:0] carry, src, held_src, lu_res;
  fbw_op_t       held_op;
  logic          lu_hit, flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wdata;
  end

  fbw_shift_flip #(.DW(DW)) shf_i (
    .carry_i (carry),
    .data_i  (cpu_wdata),
    .shamt_i (ctl_q[SHW-1:0]),
    .flip_i  (ctl_q[SHW]),
    .src_o   (src)
  );

  fbw_seq #(.AW(AW), .DW(DW)) seq_i (
    .clk       (clk),
    .rst_n_s   (rst_n_s),
    .cpu_we    (cpu_we),
    .cpu_alias (cpu_alias),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .src_i     (src),
    .op_i      (ctl_q[CW-1:CW-OPW]),
    .lu_res_i  (lu_res),
    .lu_hit_i  (lu_hit),
    .stat_re   (stat_re),
    .carry_o   (carry),
    .byte_o    (held_src),
    .op_o      (held_op),
    .cpu_ready (cpu_ready),
    .fb_re     (fb_re),
    .fb_we     (fb_we),
    .fb_addr   (fb_addr),
    .fb_wdata  (fb_wdata),
    .flag_o    (flag)
  );

  fbw_logic_unit #(.DW(DW)) lu_i (
    .op_i  (held_op),
    .s_i   (held_src),
    .d_i   (fb_rdata),
    .res_o (lu_res),
    .hit_o (lu_hit)
  );

  assign stat_rdata = {flag, {(DW-1){1'b0}}};
endmodule

// File: rtl/fbw_writer_chk.sv
module fbw_writer_chk #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_we,
  input logic          cpu_alias,
  input logic [DW-1:0] cpu_wdata,
  input logic          cpu_ready,
  input logic          stat_re,
  input logic [DW-1:0] stat_rdata,
  input logic          fb_re,
  input logic          fb_we,
  input logic [AW-1:0] fb_addr,
  input logic [DW-1:0] fb_wdata
);
  // R8: read is followed by the write-back at the same address
  assert_rd_then_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fb_re |=> (fb_we && $stable(fb_addr)));

  // R8: the CPU is stalled during buffer access
  assert_busy_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_re || fb_we) |-> !cpu_ready);

  // R8: an accepted alias store starts with a read
  assert_alias_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_ready && cpu_alias) |=> (fb_re && !fb_we));

  // R2: a direct store writes the data as given, with no read
  assert_direct_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_ready && !cpu_alias) |=>
      (fb_we && !fb_re && fb_wdata == $past(cpu_wdata)));

  // R6: only bit 7 of the status carries information
  assert_status_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[DW-2:0] == '0);

  // R7: a read with no write-back in the same cycle leaves the flag clear
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_re && !fb_we) |=> !stat_rdata[DW-1]);
endmodule

bind fbw_writer fbw_writer_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_we     (cpu_we),
  .cpu_alias  (cpu_alias),
  .cpu_wdata  (cpu_wdata),
  .cpu_ready  (cpu_ready),
  .stat_re    (stat_re),
  .stat_rdata (stat_rdata),
  .fb_re      (fb_re),
  .fb_we      (fb_we),
  .fb_addr    (fb_addr),
  .fb_wdata   (fb_wdata)
);

// File: tb/fbw_writer_tb_top.sv
module fbw_writer_tb_top;
  localparam int unsigned AW = 13;
  localparam int unsigned DW = 8;
  localparam int unsigned NV = 16;

  // {ctl, carry byte, data, dest, expected write-back, expected flag}
  localparam logic [47:0] VEC [NV] = '{
    48'h00_00_A5_CC_A5_01, 48'h13_05_80_0F_BF_00,
    48'h28_00_01_80_FF_01, 48'h30_00_00_00_FF_00,
    48'h47_FF_00_3C_3C_01, 48'h50_00_55_9A_9A_01,
    48'h60_00_0F_3C_CC_01, 48'h7C_0A_F0_00_0A_00,
    48'h80_00_FF_0F_F0_01, 48'h91_01_00_81_01_01,
    48'hA0_00_12_0F_F0_01, 48'hB0_00_F0_3C_CF_01,
    48'hC0_00_FF_FF_00_01, 48'hD0_00_0F_FF_F0_01,
    48'hE0_00_0F_30_C0_00, 48'hF0_00_3C_00_C3_00
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctl_we = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic          cpu_we = 1'b0;
  logic          cpu_alias = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic          stat_re = 1'b0;
  logic [DW-1:0] stat_rdata;
  logic          fb_re, fb_we;
  logic [AW-1:0] fb_addr;
  logic [DW-1:0] fb_wdata;
  logic [DW-1:0] fb_rdata = '0;
  logic [DW-1:0] mem [2**AW];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (fb_re) fb_rdata <= mem[fb_addr];
    if (fb_we) mem[fb_addr] <= fb_wdata;
  end

  fbw_writer #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cpu_we(cpu_we), .cpu_alias(cpu_alias), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .stat_re(stat_re),
    .stat_rdata(stat_rdata), .fb_re(fb_re), .fb_we(fb_we),
    .fb_addr(fb_addr), .fb_wdata(fb_wdata), .fb_rdata(fb_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_merge(input logic [3:0] op, input logic [7:0] s,
                                           input logic [7:0] d);
    logic [7:0] r;
    unique case (op)
      4'h0: r = s;         4'h1: r = s | d;
      4'h2: r = s | ~d;    4'h3: r = 8'hFF;
      4'h4: r = s & d;     4'h5: r = d;
      4'h6: r = ~(s ^ d);  4'h7: r = ~s | d;
      4'h8: r = s & ~d;    4'h9: r = s ^ d;
      4'hA: r = ~d;        4'hB: r = ~(s & d);
      4'hC: r = 8'h00;     4'hD: r = ~s & d;
      4'hE: r = ~(s | d);  default: r = ~s;
    endcase
    return r;
  endfunction

  task automatic cpu_wr(input logic [AW-1:0] a, input logic [7:0] d, input bit al,
                        output int busy);
    @(negedge clk);
    cpu_we = 1'b1; cpu_alias = al; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    busy = 0;
    while (!cpu_ready) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic ctl_wr(input logic [7:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic stat_rd(output logic [7:0] v);
    @(negedge clk);
    stat_re = 1'b1;
    v = stat_rdata;
    @(negedge clk);
    stat_re = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int busy;
    logic [7:0] sv;
    for (int k = 0; k < 2**AW; k++) mem[k] = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cpu_ready == 1'b1, "R1 ready", int'(cpu_ready), 1);
    chk(fb_we == 1'b0 && fb_re == 1'b0, "R1 fb idle", int'({fb_re, fb_we}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(stat_rdata == 8'h00, "R1 status", int'(stat_rdata), 0);
    // R1: control resets to 0 (shift 0, no flip, copy source)
    cpu_wr(13'h0010, 8'h6B, 1'b1, busy);
    chk(mem[13'h0010] == 8'h6B, "R1 control zero", int'(mem[13'h0010]), 'h6B);

    // R3 R4 R5 R6: vector table
    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a;
      a = AW'(13'h0100 + v);
      cpu_wr(a, VEC[v][23:16], 1'b0, busy);
      cpu_wr(13'h1FFF, VEC[v][39:32], 1'b1, busy);
      stat_rd(sv);
      ctl_wr(VEC[v][47:40]);
      cpu_wr(a, VEC[v][31:24], 1'b1, busy);
      chk(mem[a] == VEC[v][15:8], "R3/R4/R5 vector", int'(mem[a]), int'(VEC[v][15:8]));
      stat_rd(sv);
      chk(sv[7] == VEC[v][0], "R6 vector flag", int'(sv), int'(VEC[v][0]) << 7);
      stat_rd(sv);
      chk(sv == 8'h00, "R7 cleared by read", int'(sv), 0);
    end

    // R5 R6: every function with walking-one source and destination
    for (int op = 0; op < 16; op++) begin
      ctl_wr({op[3:0], 4'h0});
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic [7:0] s, d, e;
          s = 8'h01 << i; d = 8'h01 << j;
          e = ref_merge(op[3:0], s, d);
          cpu_wr(13'h0200, d, 1'b0, busy);
          cpu_wr(13'h0200, s, 1'b1, busy);
          stat_rd(sv);
          chk(mem[13'h0200] == e && sv[7] == (i == j), "R5 R6 walking",
              int'({sv[7], mem[13'h0200]}), int'({(i == j), e}));
        end
      end
    end

    // R2: a direct store does not replace the carried byte
    ctl_wr(8'h00);
    cpu_wr(13'h0300, 8'h81, 1'b1, busy);
    cpu_wr(13'h0301, 8'hFF, 1'b0, busy);
    chk(mem[13'h0301] == 8'hFF, "R2 direct data", int'(mem[13'h0301]), 'hFF);
    ctl_wr(8'h04);
    cpu_wr(13'h0302, 8'h00, 1'b1, busy);
    chk(mem[13'h0302] == 8'h10, "R2 carry kept", int'(mem[13'h0302]), 'h10);

    // R8: stall lengths
    cpu_wr(13'h0303, 8'h11, 1'b1, busy);
    chk(busy == 2, "R8 alias stall", busy, 2);
    cpu_wr(13'h0303, 8'h22, 1'b0, busy);
    chk(busy == 1, "R8 direct stall", busy, 1);

    // R9: a request while busy is dropped
    mem[13'h0400] = 8'h5A;
    @(negedge clk);
    cpu_we = 1'b1; cpu_alias = 1'b0; cpu_addr = 13'h0401; cpu_wdata = 8'h33;
    @(negedge clk);
    cpu_addr = 13'h0400; cpu_wdata = 8'hEE;
    @(negedge clk);
    cpu_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem[13'h0400] == 8'h5A, "R9 busy ignored", int'(mem[13'h0400]), 'h5A);
    chk(mem[13'h0401] == 8'h33, "R9 first store", int'(mem[13'h0401]), 'h33);

    // R10: control change during a store
    ctl_wr(8'h00);
    @(negedge clk);
    cpu_we = 1'b1; cpu_alias = 1'b1; cpu_addr = 13'h0500; cpu_wdata = 8'h77;
    @(negedge clk);
    cpu_we = 1'b0; ctl_we = 1'b1; ctl_wdata = 8'hC8;
    @(negedge clk);
    ctl_we = 1'b0;
    @(negedge clk);
    chk(mem[13'h0500] == 8'h77, "R10 settings held", int'(mem[13'h0500]), 'h77);

    // R7: set wins over a coinciding read
    ctl_wr(8'h00);
    stat_rd(sv);
    mem[13'h0600] = 8'h08;
    @(negedge clk);
    cpu_we = 1'b1; cpu_alias = 1'b1; cpu_addr = 13'h0600; cpu_wdata = 8'h0C;
    @(negedge clk);
    cpu_we = 1'b0;
    @(negedge clk);
    stat_re = 1'b1;
    sv = stat_rdata;
    chk(sv == 8'h00, "R7 before set", int'(sv), 0);
    @(negedge clk);
    stat_re = 1'b0;
    chk(stat_rdata == 8'h80, "R7 set wins", int'(stat_rdata), 'h80);
    repeat (3) @(negedge clk);
    chk(stat_rdata == 8'h80, "R7 sticky", int'(stat_rdata), 'h80);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule